// File: doc/BRIEF.md
# Seven-Level Inverter Switch Sequencer

This block drives the six power switches of a single-phase seven-level inverter. The inverter pairs a two-switch capacitor selector with a four-switch full bridge. The selector offers one third, two thirds or all of the DC link to the bridge. The bridge then passes that voltage through either way round, or shorts the load to zero. The block takes a signed sample of the grid voltage, a sample of the larger capacitor's voltage and one PWM bit from an upstream modulator. From these it decides which half of the grid cycle applies and which of three voltage bands the grid magnitude sits in. In each of the six resulting modes it holds some switches on, holds the rest off, and lets exactly one switch follow the PWM bit. Every PWM edge therefore moves the output by a single one-third step.

The grid polarity and the band are re-evaluated only on a carrier-boundary strobe. A mode change therefore never truncates a pulse already in progress. A programmable hysteresis margin surrounds zero and both band thresholds, so noisy samples near a boundary do not make the mode chatter. The larger capacitor carries two thirds of the link. Half its reading marks the one-third threshold, and the full reading marks the two-thirds threshold. All gate outputs come from flip-flops. An enable input forces every gate off.

Top module: `mli_gate_ctrl`

## Requirements
- R1: While reset is asserted, all six gate outputs are 0. On leaving reset, the stored polarity is positive and the stored band is low.
- R2: When `en` is sampled low on a clock edge, all six gates are 0 after that edge. The polarity and band registers keep updating on strobes while disabled, and gating resumes in the tracked mode once `en` returns high.
- R3: Polarity uses hysteresis `hyst` around zero. A stored positive polarity turns negative only when `v_grid < -hyst`. A stored negative polarity turns positive only when `v_grid > hyst`. Otherwise it holds.
- R4: The band thresholds are T1 = floor(`v_cap`/2) and T2 = `v_cap`, applied to |`v_grid`|. Crossing a threshold upward requires magnitude > T + `hyst`. Dropping back requires magnitude < T - `hyst`. Low is below T1, middle is between T1 and T2, and high is above T2.
- R5: Polarity and band change only on a clock edge where `carrier_strobe` is 1. A strobe at edge k updates the mode, and the gates show the new mode after edge k+1.
- R6: Positive half, low band: S4 on, SS1, SS2, S2 and S3 off, S1 = pwm.
- R7: Positive half, middle band: S1 and S4 on, SS1, S2 and S3 off, SS2 = pwm.
- R8: Positive half, high band: S1, S4 and SS2 on, S2 and S3 off, SS1 = pwm.
- R9: Negative half, low band: S2 on, SS1, SS2, S1 and S4 off, S3 = pwm.
- R10: Negative half: in the middle band S2 and S3 are on, S1, S4 and SS1 are off, and SS2 = pwm. In the high band S2, S3 and SS2 are on, S1 and S4 are off, and SS1 = pwm.
- R11: With the mode fixed and enabled, a pwm change flips exactly one gate, and S1/S2 or S3/S4 are never on together.
- R12: Gates are registered. A pwm value sampled at edge k appears on the gates only after edge k, never before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Gate enable; low forces all gates off |
| carrier_strobe | input | 1 | Carrier boundary pulse; mode may change only here |
| v_grid | input | VW | Signed grid voltage sample |
| v_cap | input | VW | Unsigned sample of the two-thirds capacitor |
| hyst | input | HW | Hysteresis margin in sample units |
| pwm | input | 1 | Modulator output bit |
| gate_ss1 | output | 1 | Selector switch that adds the smaller capacitor |
| gate_ss2 | output | 1 | Selector switch for the larger capacitor |
| gate_s1 | output | 1 | Bridge switch, positive leg high side |
| gate_s2 | output | 1 | Bridge switch, positive leg low side |
| gate_s3 | output | 1 | Bridge switch, negative leg high side |
| gate_s4 | output | 1 | Bridge switch, negative leg low side |

## Verification
The hardest case to reach is the hysteresis dead zone. The mode must hold even though the sample has crossed the bare threshold. This only shows up when the previous strobe left the mode on a particular side. The stimulus walks the grid sample up and down across each threshold in one-unit steps on successive strobes, touching exactly T+hyst, T+hyst+1, T-hyst and T-hyst-1. It also moves the sample between strobes, confirming that nothing reacts before the boundary pulse.

// File: rtl/mli_gate_pkg.sv
package mli_gate_pkg;
  typedef enum logic [1:0] {
    BAND_LO  = 2'd0,
    BAND_MID = 2'd1,
    BAND_HI  = 2'd2
  } band_e;

  typedef struct packed {
    logic ss1;
    logic ss2;
    logic s1;
    logic s2;
    logic s3;
    logic s4;
  } gate_t;

  localparam gate_t GATES_OFF = '{default: 1'b0};
endpackage

// File: rtl/mli_pol_det.sv
module mli_pol_det #(
  parameter int VW = 12,
  parameter int HW = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic signed [VW-1:0] v_grid,
  input  logic        [HW-1:0] hyst,
  output logic                 pos_q
);
  localparam int EW = VW + 2;

  logic signed [EW-1:0] v_s;
  logic signed [EW-1:0] h_s;
  logic                 pos_d;
  logic                 in_dead;

  always_comb begin
    v_s     = {{(EW-VW){v_grid[VW-1]}}, v_grid};
    h_s     = {{(EW-HW){1'b0}}, hyst};
    in_dead = (v_s >= -h_s) && (v_s <= h_s);
    if (pos_q) pos_d = !(v_s < -h_s);
    else       pos_d = (v_s > h_s);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pos_q <= 1'b1;
    else if (load) pos_q <= pos_d;
  end

  // R3: a sample inside the dead zone never flips polarity
  p_dead_zone_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (load && in_dead) |=> $stable(pos_q));
  // R5: no strobe, no polarity change
  p_pol_needs_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(pos_q));
endmodule

// File: rtl/mli_band_det.sv
module mli_band_det
  import mli_gate_pkg::*;
#(
  parameter int VW = 12,
  parameter int HW = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic signed [VW-1:0] v_grid,
  input  logic        [VW-1:0] v_cap,
  input  logic        [HW-1:0] hyst,
  output band_e                band_q
);
  localparam int EW = VW + 3;

  logic signed [EW-1:0] v_s, mag_s, h_s, t1_s, t2_s;
  logic                 above1, above2;
  band_e                band_d;

  always_comb begin
    v_s   = {{(EW-VW){v_grid[VW-1]}}, v_grid};
    mag_s = v_s[EW-1] ? -v_s : v_s;
    h_s   = {{(EW-HW){1'b0}}, hyst};
    t1_s  = {{(EW-VW+1){1'b0}}, v_cap[VW-1:1]};
    t2_s  = {{(EW-VW){1'b0}}, v_cap};
    if (band_q != BAND_LO) above1 = !(mag_s < t1_s - h_s);
    else                   above1 = (mag_s > t1_s + h_s);
    if (band_q == BAND_HI) above2 = !(mag_s < t2_s - h_s);
    else                   above2 = (mag_s > t2_s + h_s);
    if (above2)      band_d = BAND_HI;
    else if (above1) band_d = BAND_MID;
    else             band_d = BAND_LO;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    band_q <= BAND_LO;
    else if (load) band_q <= band_d;
  end

  // R5: band only moves on a strobe
  p_band_needs_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(band_q));
  // R4: leaving the low band needs the full upward margin
  p_rise_margin_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (load && band_q == BAND_LO && mag_s <= t1_s + h_s && mag_s <= t2_s + h_s)
      |=> band_q == BAND_LO);
endmodule

// File: rtl/mli_gate_map.sv
module mli_gate_map
  import mli_gate_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en,
  input  logic  pos,
  input  band_e band,
  input  logic  pwm,
  output gate_t gate_q
);
  gate_t gate_d;

  always_comb begin
    gate_d = GATES_OFF;
    if (en) begin
      if (pos) begin
        gate_d.s4 = 1'b1;
        unique case (band)
          BAND_MID: begin gate_d.s1 = 1'b1; gate_d.ss2 = pwm; end
          BAND_HI:  begin gate_d.s1 = 1'b1; gate_d.ss2 = 1'b1; gate_d.ss1 = pwm; end
          default:  gate_d.s1 = pwm;
        endcase
      end else begin
        gate_d.s2 = 1'b1;
        unique case (band)
          BAND_MID: begin gate_d.s3 = 1'b1; gate_d.ss2 = pwm; end
          BAND_HI:  begin gate_d.s3 = 1'b1; gate_d.ss2 = 1'b1; gate_d.ss1 = pwm; end
          default:  gate_d.s3 = pwm;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gate_q <= GATES_OFF;
    else        gate_q <= gate_d;
  end

  // R2: disable clears every gate on the next edge
  p_off_when_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> gate_q == GATES_OFF);
  // R11: one gate moves per cycle while the mode is fixed
  p_single_toggle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && (|gate_q) && $stable(pos) && $stable(band))
      |=> $countones(gate_q ^ $past(gate_q)) <= 1);
  // R11: a bridge leg is never shorted
  p_leg_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_q.s1 && gate_q.s2) && !(gate_q.s3 && gate_q.s4));
endmodule

// File: rtl/mli_gate_ctrl.sv
module mli_gate_ctrl
  import mli_gate_pkg::*;
#(
  parameter int VW = 12,
  parameter int HW = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 carrier_strobe,
  input  logic signed [VW-1:0] v_grid,
  input  logic        [VW-1:0] v_cap,
  input  logic        [HW-1:0] hyst,
  input  logic                 pwm,
  output logic                 gate_ss1,
  output logic                 gate_ss2,
  output logic                 gate_s1,
  output logic                 gate_s2,
  output logic                 gate_s3,
  output logic                 gate_s4
);
  logic  pos_q;
  band_e band_q;
  gate_t gates;

  mli_pol_det #(.VW(VW), .HW(HW)) u_pol (
    .clk(clk), .rst_n(rst_n), .load(carrier_strobe),
    .v_grid(v_grid), .hyst(hyst), .pos_q(pos_q)
  );

  mli_band_det #(.VW(VW), .HW(HW)) u_band (
    .clk(clk), .rst_n(rst_n), .load(carrier_strobe),
    .v_grid(v_grid), .v_cap(v_cap), .hyst(hyst), .band_q(band_q)
  );

  mli_gate_map u_map (
    .clk(clk), .rst_n(rst_n), .en(en), .pos(pos_q),
    .band(band_q), .pwm(pwm), .gate_q(gates)
  );

  assign gate_ss1 = gates.ss1;
  assign gate_ss2 = gates.ss2;
  assign gate_s1  = gates.s1;
  assign gate_s2  = gates.s2;
  assign gate_s3  = gates.s3;
  assign gate_s4  = gates.s4;

  // R1: reset state of the mode registers, seen once reset releases
  p_reset_mode_r1: assert property (@(posedge clk)
    !rst_n |=> (!rst_n || (pos_q && band_q == BAND_LO) || $past(carrier_strobe)));
endmodule

// File: tb/sim_mli_gate_ctrl.sv
module sim_mli_gate_ctrl;
  localparam int VW = 12;
  localparam int HW = 6;

  logic clk = 1'b0;
  logic rst_n, en, carrier_strobe, pwm;
  logic signed [VW-1:0] v_grid;
  logic [VW-1:0] v_cap;
  logic [HW-1:0] hyst;
  logic g_ss1, g_ss2, g_s1, g_s2, g_s3, g_s4;
  int total = 0;
  int bad = 0;

  // gate vector order {ss1,ss2,s1,s2,s3,s4}
  localparam logic [5:0] PL0 = 6'b000001, PL1 = 6'b001001;
  localparam logic [5:0] PM0 = 6'b001001, PM1 = 6'b011001;
  localparam logic [5:0] PH0 = 6'b011001, PH1 = 6'b111001;
  localparam logic [5:0] NL0 = 6'b000100, NL1 = 6'b000110;
  localparam logic [5:0] NM0 = 6'b000110, NM1 = 6'b010110;
  localparam logic [5:0] NH0 = 6'b010110, NH1 = 6'b110110;

  always #5 clk = ~clk;

  mli_gate_ctrl #(.VW(VW), .HW(HW)) u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .carrier_strobe(carrier_strobe),
    .v_grid(v_grid), .v_cap(v_cap), .hyst(hyst), .pwm(pwm),
    .gate_ss1(g_ss1), .gate_ss2(g_ss2), .gate_s1(g_s1),
    .gate_s2(g_s2), .gate_s3(g_s3), .gate_s4(g_s4)
  );

  function automatic logic [5:0] gv();
    return {g_ss1, g_ss2, g_s1, g_s2, g_s3, g_s4};
  endfunction

  task automatic chk(input logic [5:0] act, input logic [5:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic apply(input int v);
    @(negedge clk);
    v_grid = VW'(v);
    carrier_strobe = 1'b1;
    @(negedge clk);
    carrier_strobe = 1'b0;
    @(negedge clk);
  endtask

  task automatic check_mode(input logic [5:0] e0, input logic [5:0] e1, input string tag);
    logic [5:0] g0, g1;
    pwm = 1'b0;
    @(negedge clk);
    g0 = gv();
    chk(g0, e0, {tag, " pwm=0"});
    pwm = 1'b1;
    #1;
    chk(gv(), g0, {tag, " R12 no change before edge"});
    @(negedge clk);
    g1 = gv();
    chk(g1, e1, {tag, " pwm=1"});
    chk(6'($countones(g0 ^ g1)), 6'd1, {tag, " R11 one switch toggles"});
    chk(6'({(g1[3] & g1[2]) | (g1[1] & g1[0])}), 6'd0, {tag, " R11 leg exclusive"});
    pwm = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; en = 1'b1; carrier_strobe = 1'b0; pwm = 1'b1;
    v_grid = '0; v_cap = 12'd1200; hyst = 6'd20;
    repeat (3) @(negedge clk);
    chk(gv(), 6'b0, "R1 gates off in reset");
    rst_n = 1'b1;
    pwm = 1'b0;
    @(negedge clk);
    chk(gv(), PL0, "R1 positive low after reset");
  endtask

  task automatic t_pos_bands();
    apply(300);  check_mode(PL0, PL1, "R6 pos low");
    apply(900);  check_mode(PM0, PM1, "R7 pos mid");
    apply(1500); check_mode(PH0, PH1, "R8 pos high");
  endtask

  task automatic t_neg_bands();
    apply(-300);  check_mode(NL0, NL1, "R9 neg low");
    apply(-900);  check_mode(NM0, NM1, "R10 neg mid");
    apply(-1500); check_mode(NH0, NH1, "R10 neg high");
  endtask

  task automatic t_band_hyst();
    apply(300);  check_mode(PL0, PL1, "R4 start low");
    apply(620);  check_mode(PL0, PL1, "R4 T1+h stays low");
    apply(621);  check_mode(PM0, PM1, "R4 T1+h+1 rises");
    apply(580);  check_mode(PM0, PM1, "R4 T1-h stays mid");
    apply(579);  check_mode(PL0, PL1, "R4 T1-h-1 falls");
    apply(900);  check_mode(PM0, PM1, "R4 mid again");
    apply(1220); check_mode(PM0, PM1, "R4 T2+h stays mid");
    apply(1221); check_mode(PH0, PH1, "R4 T2+h+1 rises");
    apply(1180); check_mode(PH0, PH1, "R4 T2-h stays high");
    apply(1179); check_mode(PM0, PM1, "R4 T2-h-1 falls");
  endtask

  task automatic t_pol_hyst();
    apply(300);  check_mode(PL0, PL1, "R3 start pos");
    apply(-20);  check_mode(PL0, PL1, "R3 -h holds pos");
    apply(-21);  check_mode(NL0, NL1, "R3 -h-1 goes neg");
    apply(20);   check_mode(NL0, NL1, "R3 +h holds neg");
    apply(21);   check_mode(PL0, PL1, "R3 +h+1 goes pos");
  endtask

  task automatic t_strobe_gate();
    apply(300);
    @(negedge clk);
    v_grid = -12'sd1500;
    repeat (5) @(negedge clk);
    check_mode(PL0, PL1, "R5 no strobe keeps mode");
    apply(-1500);
    check_mode(NH0, NH1, "R5 strobe takes new mode");
  endtask

  task automatic t_enable();
    apply(300);
    pwm = 1'b1;
    @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk(gv(), 6'b0, "R2 disable clears gates");
    apply(900);
    chk(gv(), 6'b0, "R2 stays off while disabled");
    en = 1'b1;
    check_mode(PM0, PM1, "R2 resumes in tracked mode");
  endtask

  initial begin
    t_reset();
    t_pos_bands();
    t_neg_bands();
    t_band_hyst();
    t_pol_hyst();
    t_strobe_gate();
    t_enable();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule